// File: doc/BRIEF.md
# Thermal Contrast Heater Controller

This block decides when a swipe-style thermal image sensor's on-die warming element should be switched on. The sensor reports, once per frame, a 4-bit differential temperature code. Code 8 means no change from the comparison point. Each step near the middle is worth roughly 1.4 K, and the steps widen toward the ends. Codes 0 and 15 are saturated: they give only a bound and not a value. When the image path raises a low-contrast flag, the controller takes the next frame's code as its baseline. It then drives the heater enable until the code has climbed two steps above that baseline, or until the code reaches the top of the scale, or until a frame budget runs out.

Running out of the budget marks a sticky fault. After every heat cycle the controller waits a programmable number of frames before it can be triggered again. Nap mode forces the heater off at once and abandons any cycle in progress.

Temperature codes arrive on a valid/ready stream. The controller never exerts back-pressure: `tcode_ready` is held high, so every cycle with `tcode_valid` high delivers one frame's code and no stall rule applies. Cycles with `tcode_valid` low carry no code.

Top module: `thermal_heater_ctrl`

## Requirements
- R1: After `rst_n` is released, `heat_en` and `fault` are 0 and `tcode_ready` is 1; `tcode_ready` stays 1 at all times.
- R2: A high `low_contrast` seen while idle and out of nap arms the controller, with the heater still off. The first code accepted after that becomes the baseline, and `heat_en` goes high in the cycle after that code is accepted.
- R3: While heating, a code that is at least baseline+2 (plain unsigned 4-bit values) ends the cycle: `heat_en` is low in the cycle after that code is accepted.
- R4: Code 15 is treated as saturated high. During heating it ends the cycle the same way as R3. As a baseline it ends the cycle at once, so the heater never turns on.
- R5: If the Nth heated code (N = `cfg_timeout`, with 0 treated as 1) does not meet R3 or R4, the heater goes low after that code and `fault` goes high. If that same code meets R3, it ends the cycle without a fault.
- R6: `fault` stays high until `rst_n` is asserted, and later heat cycles still run normally.
- R7: After a heat cycle ends, `low_contrast` is ignored until `cfg_cooldown` further codes have been accepted. The controller is idle one cycle after that.
- R8: While `nap` is high, `heat_en` is low in that same cycle and `low_contrast` is ignored. A nap during a cycle returns the controller to idle with no fault and no cooldown.
- R9: `low_contrast` seen while armed or heating has no effect; the baseline already captured is kept.
- R10: Cycles with `tcode_valid` low are ignored: they neither set a baseline nor end heating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nap | input | 1 | Nap mode: heater forced off, controller idle |
| low_contrast | input | 1 | Image-contrast-too-low flag from the image path |
| tcode_valid | input | 1 | Temperature code present this cycle |
| tcode_ready | output | 1 | Always 1: code always accepted |
| tcode | input | 4 | Differential temperature code (8 = no change) |
| cfg_timeout | input | 8 | Heated-frame budget per cycle (0 acts as 1) |
| cfg_cooldown | input | 8 | Frames to wait after a cycle before re-arming |
| heat_en | output | 1 | Heater enable |
| fault | output | 1 | Sticky: a heat cycle ran out of budget |

## Verification
Every result here appears one clock after the input that causes it, except for nap. A code accepted at an edge changes `heat_en` and `fault` right after that edge. A `low_contrast` pulse only arms the controller, so the heater moves one accepted code later. Nap acts on `heat_en` within the same cycle. The bench drives inputs on falling edges. It samples registered results at the next falling edge, and it samples the nap result a nanosecond after driving `nap`. It sweeps every baseline from 0 to 15 with rising codes, and every timeout from 0 to 5, and it computes the expected enable and fault from the rules above.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HEAT = 2'd2,
    ST_COOL = 2'd3
  } hc_state_e;
endpackage

// File: rtl/hc_code_judge.sv
// Compares a live temperature code with the captured baseline.
module hc_code_judge #(
  parameter int CODE_W = 4,
  parameter int RISE   = 2
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] base,
  output logic              reached,
  output logic              at_top
);
  localparam int EW = CODE_W + 2;
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  // Widened compare so that base+RISE past the scale top never wraps.
  assign reached = (EW'(code) >= (EW'(base) + EW'(RISE)));
  assign at_top  = (code == CODE_TOP);
endmodule

// File: rtl/hc_frame_ctr.sv
// Saturating frame counter, cleared on every controller state change.
module hc_frame_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)            cnt <= '0;
    else if (inc && cnt != CMAX)  cnt <= cnt + 1'b1;
  end

  // R7: the counter moves by at most one per cycle and only when told to
  p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/thermal_heater_ctrl.sv
module thermal_heater_ctrl
  import hc_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int RISE   = 2,
  parameter int TMO_W  = 8,
  parameter int COOL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nap,
  input  logic              low_contrast,
  input  logic              tcode_valid,
  output logic              tcode_ready,
  input  logic [CODE_W-1:0] tcode,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [COOL_W-1:0] cfg_cooldown,
  output logic              heat_en,
  output logic              fault
);
  localparam int CNT_W = (TMO_W > COOL_W) ? TMO_W : COOL_W;
  localparam int LW    = CNT_W + 1;

  hc_state_e         state_q, state_d;
  logic [CODE_W-1:0] base_q;
  logic              fault_q;
  logic              fault_set, base_cap;
  logic              reached, at_top;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr, cnt_inc;
  logic [LW-1:0]     tmo_lim;
  logic              expire, cool_done;

  hc_code_judge #(.CODE_W(CODE_W), .RISE(RISE)) u_judge (
    .code    (tcode),
    .base    (base_q),
    .reached (reached),
    .at_top  (at_top)
  );

  hc_frame_ctr #(.W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  // Budget of heated frames; zero behaves as one.
  assign tmo_lim   = (cfg_timeout == '0) ? LW'(1) : LW'(cfg_timeout);
  assign expire    = ((LW'(cnt) + LW'(1)) >= tmo_lim);
  assign cool_done = (cnt >= CNT_W'(cfg_cooldown));

  always_comb begin
    state_d   = state_q;
    fault_set = 1'b0;
    base_cap  = 1'b0;
    if (nap) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (low_contrast) state_d = ST_ARM;
        ST_ARM: if (tcode_valid) begin
          base_cap = 1'b1;
          state_d  = at_top ? ST_COOL : ST_HEAT;
        end
        ST_HEAT: if (tcode_valid) begin
          if (reached || at_top) begin
            state_d = ST_COOL;
          end else if (expire) begin
            state_d   = ST_COOL;
            fault_set = 1'b1;
          end
        end
        ST_COOL: if (cool_done) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign cnt_clr = (state_d != state_q);
  assign cnt_inc = tcode_valid && ((state_q == ST_HEAT) || (state_q == ST_COOL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (base_cap)  base_q  <= tcode;
      if (fault_set) fault_q <= 1'b1;
    end
  end

  assign heat_en     = (state_q == ST_HEAT) && !nap;
  assign fault       = fault_q;
  assign tcode_ready = 1'b1;

  // R2: a baseline below the top turns the heater on next cycle
  p_heat_after_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && tcode_valid && !at_top && !nap) |=> (heat_en || nap));
  // R3: a code at baseline+2 or above ends heating
  p_stop_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (heat_en && tcode_valid && reached) |=> !heat_en);
  // R4: a saturated-high baseline never starts heating
  p_top_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && tcode_valid && at_top) |=> !heat_en);
  // R5: a fault appears only as heating ends
  p_fault_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !heat_en);
  // R6: fault is sticky
  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  // R7: no heating straight out of cooldown
  p_cool_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COOL) |=> !heat_en);
  // R8: nap sends the controller to idle
  p_nap_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nap |=> (state_q == ST_IDLE));
endmodule

// File: tb/thermal_heater_ctrl_tb.sv
module thermal_heater_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nap = 1'b0;
  logic       low_contrast = 1'b0;
  logic       tcode_valid = 1'b0;
  logic       tcode_ready;
  logic [3:0] tcode = 4'd0;
  logic [7:0] cfg_timeout = 8'd20;
  logic [7:0] cfg_cooldown = 8'd0;
  logic       heat_en, fault;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thermal_heater_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nap(nap), .low_contrast(low_contrast),
    .tcode_valid(tcode_valid), .tcode_ready(tcode_ready), .tcode(tcode),
    .cfg_timeout(cfg_timeout), .cfg_cooldown(cfg_cooldown),
    .heat_en(heat_en), .fault(fault)
  );

  task automatic ck(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [3:0] c);
    tcode = c; tcode_valid = 1'b1;
    @(negedge clk);
    tcode_valid = 1'b0;
  endtask

  task automatic trig();
    low_contrast = 1'b1;
    @(negedge clk);
    low_contrast = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    ck(heat_en, 1'b0, "R1 heat_en");
    ck(fault, 1'b0, "R1 fault");
    ck(tcode_ready, 1'b1, "R1 ready");

    // R2/R3/R4 sweep over every baseline with codes rising by one per frame
    for (int b = 0; b < 16; b++) begin
      trig();
      ck(heat_en, 1'b0, "R2 armed but off");
      send(4'(b));
      ck(heat_en, (b != 15), "R2/R4 on after baseline");
      if (b != 15) begin
        for (int c = b; c < 16; c++) begin
          logic stop;
          stop = (c >= b + 2) || (c == 15);
          send(4'(c));
          ck(heat_en, !stop, "R3/R4 rise stop");
          if (stop) break;
        end
      end
      @(negedge clk);
      ck(fault, 1'b0, "R3 no fault");
    end

    // R9: trigger while heating keeps the baseline
    trig(); send(4'd5); send(4'd6);
    ck(heat_en, 1'b1, "R9 heating");
    trig();
    send(4'd6);
    ck(heat_en, 1'b1, "R9 not re-armed");
    send(4'd7);
    ck(heat_en, 1'b0, "R9 baseline kept");
    @(negedge clk);

    // R10: invalid cycles ignored
    trig();
    tcode = 4'd3; @(negedge clk);
    ck(heat_en, 1'b0, "R10 no baseline from invalid");
    send(4'd9);
    ck(heat_en, 1'b1, "R10 baseline 9");
    tcode = 4'd11; @(negedge clk);
    ck(heat_en, 1'b1, "R10 invalid 11 ignored");
    send(4'd10);
    ck(heat_en, 1'b1, "R10 10 below target");
    send(4'd11);
    ck(heat_en, 1'b0, "R10 11 reaches target");
    ck(tcode_ready, 1'b1, "R1 ready held");
    @(negedge clk);

    // R7: cooldown of three frames
    cfg_cooldown = 8'd3;
    trig(); send(4'd8); send(4'd10);
    ck(heat_en, 1'b0, "R7 cycle ended");
    send(4'd8); send(4'd8);
    trig();
    send(4'd8);
    ck(heat_en, 1'b0, "R7 trigger ignored in cooldown");
    @(negedge clk);
    trig(); send(4'd8);
    ck(heat_en, 1'b1, "R7 re-armed after cooldown");
    send(4'd10);
    ck(heat_en, 1'b0, "R7 second cycle end");

    // R8: nap with a long cooldown configured
    cfg_cooldown = 8'd5;
    do_reset();
    trig(); send(4'd8);
    ck(heat_en, 1'b1, "R8 heating before nap");
    nap = 1'b1; #1;
    ck(heat_en, 1'b0, "R8 same-cycle off");
    @(negedge clk);
    nap = 1'b0;
    ck(fault, 1'b0, "R8 no fault");
    trig(); send(4'd8);
    ck(heat_en, 1'b1, "R8 no cooldown after nap");
    nap = 1'b1; @(negedge clk); nap = 1'b0;
    nap = 1'b1; low_contrast = 1'b1; @(negedge clk);
    low_contrast = 1'b0; nap = 1'b0;
    send(4'd8);
    ck(heat_en, 1'b0, "R8 trigger ignored in nap");
    cfg_cooldown = 8'd0;

    // R5: timeout sweep, constant code
    for (int t = 0; t < 6; t++) begin
      int lim;
      lim = (t == 0) ? 1 : t;
      cfg_timeout = 8'(t);
      do_reset();
      trig(); send(4'd8);
      ck(heat_en, 1'b1, "R5 on");
      for (int k = 1; k <= lim; k++) begin
        send(4'd9);
        ck(heat_en, (k < lim), "R5 timeout heat");
        ck(fault, (k >= lim), "R5 timeout fault");
      end
    end

    // R6: fault stays, next cycle still works
    @(negedge clk);
    cfg_timeout = 8'd20;
    trig(); send(4'd8);
    ck(heat_en, 1'b1, "R6 runs after fault");
    send(4'd10);
    ck(heat_en, 1'b0, "R6 stop");
    ck(fault, 1'b1, "R6 sticky");
    do_reset();
    ck(fault, 1'b0, "R6 cleared by reset");

    // R5: target wins over timeout on the same frame
    cfg_timeout = 8'd2;
    trig(); send(4'd8); send(4'd9); send(4'd10);
    ck(heat_en, 1'b0, "R5 priority off");
    ck(fault, 1'b0, "R5 priority no fault");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule